// File: doc/BRIEF.md
# Keyed JTAG TAP Instruction Unit

This block is the chip-level test access port controller that sits nearest the JTAG pins. It runs the sixteen-state TAP state machine and holds a six-bit instruction register. Its own data registers are the one-bit bypass register, two 32-bit identification registers and an eight-bit connect register. It decodes the current instruction and gives the active opcode, the capture, shift and update strobes and a route-select flag to an external mapped-register data path. While that flag is high, the external path supplies the serial output.

Access to the external path is guarded by a four-bit key. The route opcode takes effect only while the key holds the unlock value. With any other key value the unit treats the route opcode as a plain bypass. The key is written through the connect instruction. A write lands only when the enable bit of the shifted-in byte is set. Reset returns the key to a locked value.

Top module: `keyed_tap_unit`

## Requirements
- R1: The state machine follows the standard sixteen-state TAP graph on rising TCK edges. TMS held high for five edges reaches Test-Logic-Reset from any state. `trst_n` low forces Test-Logic-Reset asynchronously.
- R2: Reset and Test-Logic-Reset make IDCODE (000100) the active instruction. Capture-IR loads 000001, so the first six bits shifted out of an IR scan are 1,0,0,0,0,0.
- R3: Opcode 000100 selects a 32-bit register that captures `ID_CODE`. Opcode 000101 selects a 32-bit register that captures `ID2_CODE` when `SECOND_ID_EN` is 1. Both shift out LSB first.
- R4: Opcode 111111 and every reserved opcode (000000, 000001, 000011, 000110 and 001000 to 111110) select the one-bit bypass register. It captures 0, so a DR scan returns 0 followed by the input delayed by one bit.
- R5: Route opcode 000010 behaves exactly like bypass, with `route_sel` low, while the key differs from 1001. While the key is 1001, `route_sel` is high and TDO in Shift-DR follows `route_tdo`.
- R6: Opcode 000111 selects the eight-bit connect register. Capture-DR loads bit 7 with the last written enable bit, bits 6:4 with 0 and bits 3:0 with the key.
- R7: At Update-DR under opcode 000111, a shifted bit 7 of 1 replaces the four-bit key as a whole with shifted bits 3:0. A shifted bit 7 of 0 leaves the key unchanged.
- R8: The key becomes 0110 on `trst_n` and whenever the state machine is in Test-Logic-Reset. `connected` is high exactly while the key equals 1001.
- R9: TDO and `tdo_en` change only on falling TCK edges. `tdo_en` is high only in Shift-IR and Shift-DR, and TDO is 0 elsewhere.
- R10: `capture_dr`, `shift_dr` and `update_dr` are high while the state machine is in Capture-DR, Shift-DR and Update-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| route_tdo | input | 1 | Serial data from the external routed data path |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while TDO carries shift data |
| instr | output | 6 | Active opcode |
| route_sel | output | 1 | Route opcode active and key unlocked |
| connected | output | 1 | Key equals the unlock value |
| capture_dr | output | 1 | State machine in Capture-DR |
| shift_dr | output | 1 | State machine in Shift-DR |
| update_dr | output | 1 | State machine in Update-DR |

## Verification
The bench builds the unit with `SECOND_ID_EN` set and with two distinct identification values that each have bit 0 set. This makes it possible to tell the 000101 path apart from IDCODE and from bypass, and to check every captured bit of both codes. The key width and the unlock and reset values keep their defaults, so the locked, unlocked and wrong-key cases of the route opcode can all be reached with eight-bit connect scans.

// File: rtl/ktap_pkg.sv
package ktap_pkg;

   localparam int IR_W = 6;

   localparam logic [IR_W-1:0] OP_ROUTE  = 6'b000010;
   localparam logic [IR_W-1:0] OP_IDCODE = 6'b000100;
   localparam logic [IR_W-1:0] OP_ID2    = 6'b000101;
   localparam logic [IR_W-1:0] OP_KEY    = 6'b000111;
   localparam logic [IR_W-1:0] OP_BYPASS = 6'b111111;
   localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 6'b000001;

   typedef enum logic [3:0] {
      ST_TLR, ST_RTI,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UP_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UP_IR
   } tap_state_t;

   typedef enum logic [2:0] {
      SEL_BYP, SEL_ID, SEL_ID2, SEL_KEY, SEL_ROUTE
   } dr_sel_t;

   function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
      case (s)
         ST_TLR:    return m ? ST_TLR    : ST_RTI;
         ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
         ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: return m ? ST_UP_DR  : ST_PA_DR;
         ST_PA_DR:  return m ? ST_EX2_DR : ST_PA_DR;
         ST_EX2_DR: return m ? ST_UP_DR  : ST_SH_DR;
         ST_UP_DR:  return m ? ST_SEL_DR : ST_RTI;
         ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: return m ? ST_UP_IR  : ST_PA_IR;
         ST_PA_IR:  return m ? ST_EX2_IR : ST_PA_IR;
         ST_EX2_IR: return m ? ST_UP_IR  : ST_SH_IR;
         default:   return m ? ST_SEL_DR : ST_RTI;
      endcase
   endfunction

endpackage

// File: rtl/ktap_fsm.sv
module ktap_fsm
   import ktap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_t state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_TLR;
      else         state <= tap_next(state, tms);
   end

   assert_tlr_hold_R1: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_TLR && tms) |=> state == ST_TLR);
   assert_update_to_idle_R1: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_UP_DR && !tms) |=> state == ST_RTI);

endmodule

// File: rtl/ktap_ir.sv
module ktap_ir
   import ktap_pkg::*;
#(
   parameter bit SECOND_ID_EN = 1'b1
)(
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_t      state,
   input  logic            tdi,
   input  logic            connected,
   output logic [IR_W-1:0] ir_cur,
   output logic            ir_lsb,
   output dr_sel_t         sel
);

   logic [IR_W-1:0] ir_sr;
   dr_sel_t         id2_sel;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sr  <= IR_CAPTURE_PAT;
         ir_cur <= OP_IDCODE;
      end else begin
         case (state)
            ST_CAP_IR: ir_sr <= IR_CAPTURE_PAT;
            ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            default:   ir_sr <= ir_sr;
         endcase
         if (state == ST_TLR)        ir_cur <= OP_IDCODE;
         else if (state == ST_UP_IR) ir_cur <= ir_sr;
      end
   end

   assign ir_lsb = ir_sr[0];

   generate
      if (SECOND_ID_EN) begin : g_id2_on
         assign id2_sel = SEL_ID2;
      end else begin : g_id2_off
         assign id2_sel = SEL_BYP;
      end
   endgenerate

   always_comb begin
      case (ir_cur)
         OP_IDCODE: sel = SEL_ID;
         OP_ID2:    sel = id2_sel;
         OP_KEY:    sel = SEL_KEY;
         OP_ROUTE:  sel = connected ? SEL_ROUTE : SEL_BYP;
         default:   sel = SEL_BYP;
      endcase
   end

   assert_ir_capture_R2: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_CAP_IR) |=> ir_sr == IR_CAPTURE_PAT);
   assert_ir_update_R3: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_UP_IR) |=> ir_cur == $past(ir_sr));
   assert_ir_tlr_R2: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_TLR) |=> ir_cur == OP_IDCODE);

endmodule

// File: rtl/ktap_key.sv
module ktap_key
   import ktap_pkg::*;
#(
   parameter int               KEY_W      = 4,
   parameter logic [KEY_W-1:0] UNLOCK_KEY = 4'b1001,
   parameter logic [KEY_W-1:0] RESET_KEY  = 4'b0110
)(
   input  logic             tck,
   input  logic             trst_n,
   input  tap_state_t       state,
   input  logic             upd,
   input  logic             wr_en_bit,
   input  logic [KEY_W-1:0] wr_key,
   output logic [KEY_W-1:0] key,
   output logic             wen,
   output logic             connected
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         key <= RESET_KEY;
         wen <= 1'b0;
      end else if (state == ST_TLR) begin
         key <= RESET_KEY;
         wen <= 1'b0;
      end else if (upd) begin
         wen <= wr_en_bit;
         if (wr_en_bit) key <= wr_key;
      end
   end

   assign connected = (key == UNLOCK_KEY);

   assert_key_tlr_R8: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_TLR) |=> key == RESET_KEY && !connected);
   assert_key_hold_R7: assert property (@(posedge tck) disable iff (!trst_n)
      (state != ST_TLR && !(upd && wr_en_bit)) |=> $stable(key));
   assert_key_write_R7: assert property (@(posedge tck) disable iff (!trst_n)
      (state != ST_TLR && upd && wr_en_bit) |=> key == $past(wr_key));

endmodule

// File: rtl/keyed_tap_unit.sv
module keyed_tap_unit
   import ktap_pkg::*;
#(
   parameter int               ID_W         = 32,
   parameter logic [ID_W-1:0]  ID_CODE      = 32'h1000_A0C5,
   parameter logic [ID_W-1:0]  ID2_CODE     = 32'h2000_B0E3,
   parameter bit               SECOND_ID_EN = 1'b1,
   parameter int               KEY_W        = 4,
   parameter logic [KEY_W-1:0] UNLOCK_KEY   = 4'b1001,
   parameter logic [KEY_W-1:0] RESET_KEY    = 4'b0110
)(
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tms,
   input  logic            tdi,
   input  logic            route_tdo,
   output logic            tdo,
   output logic            tdo_en,
   output logic [IR_W-1:0] instr,
   output logic            route_sel,
   output logic            connected,
   output logic            capture_dr,
   output logic            shift_dr,
   output logic            update_dr
);

   localparam int KREG_W = 8;

   if (ID_W < KREG_W) begin : g_bad_idw
      $error("ID_W must cover the connect register");
   end
   if (KEY_W > KREG_W - 1) begin : g_bad_keyw
      $error("KEY_W leaves no room for the enable bit");
   end
   if (ID_CODE[0] != 1'b1 || ID2_CODE[0] != 1'b1) begin : g_bad_id
      $error("identification codes need bit 0 set");
   end
   if (UNLOCK_KEY == RESET_KEY) begin : g_bad_key
      $error("reset key must differ from the unlock key");
   end

   tap_state_t       state;
   dr_sel_t          sel;
   logic             ir_lsb;
   logic [KEY_W-1:0] key;
   logic             wen;
   logic [ID_W-1:0]  dr_sr, dr_nxt;
   logic [KREG_W-1:0] key_cap;
   logic             tdo_q, tdo_en_q;

   ktap_fsm u_fsm (
      .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
   );

   ktap_ir #(.SECOND_ID_EN(SECOND_ID_EN)) u_ir (
      .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
      .connected(connected), .ir_cur(instr), .ir_lsb(ir_lsb), .sel(sel)
   );

   ktap_key #(.KEY_W(KEY_W), .UNLOCK_KEY(UNLOCK_KEY), .RESET_KEY(RESET_KEY)) u_key (
      .tck(tck), .trst_n(trst_n), .state(state),
      .upd(state == ST_UP_DR && sel == SEL_KEY),
      .wr_en_bit(dr_sr[KREG_W-1]), .wr_key(dr_sr[KEY_W-1:0]),
      .key(key), .wen(wen), .connected(connected)
   );

   always_comb begin
      key_cap = '0;
      key_cap[KREG_W-1] = wen;
      key_cap[KEY_W-1:0] = key;
   end

   always_comb begin
      dr_nxt = dr_sr;
      if (state == ST_CAP_DR) begin
         dr_nxt = '0;
         case (sel)
            SEL_ID:  dr_nxt = ID_CODE;
            SEL_ID2: dr_nxt = ID2_CODE;
            SEL_KEY: dr_nxt[KREG_W-1:0] = key_cap;
            default: dr_nxt = '0;
         endcase
      end else if (state == ST_SH_DR) begin
         case (sel)
            SEL_ID, SEL_ID2: dr_nxt = {tdi, dr_sr[ID_W-1:1]};
            SEL_KEY:         dr_nxt[KREG_W-1:0] = {tdi, dr_sr[KREG_W-1:1]};
            default:         dr_nxt[0] = tdi;
         endcase
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) dr_sr <= '0;
      else         dr_sr <= dr_nxt;
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_q    <= 1'b0;
         tdo_en_q <= 1'b0;
      end else begin
         case (state)
            ST_SH_IR: begin
               tdo_q    <= ir_lsb;
               tdo_en_q <= 1'b1;
            end
            ST_SH_DR: begin
               tdo_q    <= (sel == SEL_ROUTE) ? route_tdo : dr_sr[0];
               tdo_en_q <= 1'b1;
            end
            default: begin
               tdo_q    <= 1'b0;
               tdo_en_q <= 1'b0;
            end
         endcase
      end
   end

   assign tdo        = tdo_q;
   assign tdo_en     = tdo_en_q;
   assign route_sel  = (sel == SEL_ROUTE);
   assign capture_dr = (state == ST_CAP_DR);
   assign shift_dr   = (state == ST_SH_DR);
   assign update_dr  = (state == ST_UP_DR);

   assert_bypass_capture_R4: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_CAP_DR && sel == SEL_BYP) |=> dr_sr[0] == 1'b0);
   assert_tdo_window_R9: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR));
   assert_tdo_quiet_R9: assert property (@(posedge tck) disable iff (!trst_n)
      !tdo_en |-> !tdo);
   assert_route_locked_R5: assert property (@(posedge tck) disable iff (!trst_n)
      (instr == OP_ROUTE && !connected) |-> !route_sel);

endmodule

// File: tb/test_keyed_tap_unit.sv
module test_keyed_tap_unit;

   localparam logic [31:0] TB_ID  = 32'h0A5C_E02F;
   localparam logic [31:0] TB_ID2 = 32'h7E11_90C3;
   localparam int NV = 7;
   localparam logic [5:0]  V_OP  [NV] = '{6'b000100, 6'b000101, 6'b111111,
                                          6'b000000, 6'b101010, 6'b000010, 6'b000111};
   localparam int          V_LEN [NV] = '{32, 32, 8, 8, 8, 8, 8};
   localparam logic [31:0] V_DIN [NV] = '{32'h0, 32'h0, 32'hA5, 32'h3C, 32'hFF, 32'h81, 32'h00};
   localparam logic [31:0] V_OUT [NV] = '{TB_ID, TB_ID2, 32'h4A, 32'h78, 32'hFE, 32'h02, 32'h06};

   logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, route_tdo = 1'b0;
   logic tdo, tdo_en, route_sel, connected, capture_dr, shift_dr, update_dr;
   logic [5:0] instr;
   int total = 0, bad = 0;
   bit finished = 0;

   always #2 tck = ~tck;

   keyed_tap_unit #(.ID_CODE(TB_ID), .ID2_CODE(TB_ID2), .SECOND_ID_EN(1'b1)) i_keyed_tap_unit (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .route_tdo(route_tdo),
      .tdo(tdo), .tdo_en(tdo_en), .instr(instr), .route_sel(route_sel),
      .connected(connected), .capture_dr(capture_dr), .shift_dr(shift_dr),
      .update_dr(update_dr)
   );

   function automatic string vreq(input int i);
      if (i < 2) return "R3";
      if (i < 5) return "R4";
      if (i == 5) return "R5";
      return "R6";
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input logic m, input logic d, output logic o);
      @(negedge tck);
      #1;
      tms = m;
      tdi = d;
      o   = tdo;
   endtask

   task automatic idle_ticks(input int n);
      logic o;
      for (int i = 0; i < n; i++) tick(1'b0, 1'b0, o);
   endtask

   task automatic tap_reset();
      logic o;
      for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
      idle_ticks(2);
   endtask

   task automatic ir_scan(input logic [5:0] op, output logic [5:0] cap);
      logic o;
      tick(1'b1, 1'b0, o);
      tick(1'b1, 1'b0, o);
      tick(1'b0, 1'b0, o);
      tick(1'b0, 1'b0, o);
      for (int i = 0; i < 6; i++) begin
         tick(i == 5, op[i], o);
         cap[i] = o;
      end
      tick(1'b1, 1'b0, o);
      idle_ticks(2);
   endtask

   task automatic dr_scan(input int len, input logic [31:0] din, output logic [31:0] dout,
                          output int n_sh, output int n_en, output int n_cap, output int n_up);
      logic o;
      dout = '0; n_sh = 0; n_en = 0; n_cap = 0; n_up = 0;
      tick(1'b1, 1'b0, o);
      tick(1'b0, 1'b0, o);
      tick(1'b0, 1'b0, o);
      if (capture_dr) n_cap++;
      for (int i = 0; i < len; i++) begin
         tick(i == len - 1, din[i], o);
         dout[i] = o;
         if (shift_dr) n_sh++;
         if (tdo_en) n_en++;
      end
      tick(1'b1, 1'b0, o);
      tick(1'b0, 1'b0, o);
      if (update_dr) n_up++;
      idle_ticks(1);
   endtask

   task automatic dr_plain(input int len, input logic [31:0] din, output logic [31:0] dout);
      int a, b, c, d;
      dr_scan(len, din, dout, a, b, c, d);
   endtask

   initial begin
      repeat (20000) @(posedge tck);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] dout;
      logic [5:0]  cap;
      logic        t1, t2, t3, o;
      int          n_sh, n_en, n_cap, n_up;

      #9;
      chk("R1 trst tdo_en", {31'b0, tdo_en}, 32'h0);
      chk("R8 reset disconnected", {31'b0, connected}, 32'h0);
      trst_n = 1'b1;
      tap_reset();
      chk("R2 reset instr", {26'b0, instr}, 32'h04);
      chk("R9 idle tdo_en", {31'b0, tdo_en}, 32'h0);

      dr_plain(32, 32'h0, dout);
      chk("R2 default IDCODE", dout, TB_ID);

      for (int v = 0; v < NV; v++) begin
         ir_scan(V_OP[v], cap);
         chk("R2 IR capture", {26'b0, cap}, 32'h01);
         dr_scan(V_LEN[v], V_DIN[v], dout, n_sh, n_en, n_cap, n_up);
         chk(vreq(v), dout, V_OUT[v]);
         if (v == 2) begin
            chk("R10 shift count", n_sh, 8);
            chk("R10 capture", n_cap, 1);
            chk("R10 update", n_up, 1);
            chk("R9 tdo_en count", n_en, 8);
         end
      end
      chk("R5 locked route_sel", {31'b0, route_sel}, 32'h0);

      // Connect register (opcode 000111 still active)
      dr_plain(8, 32'h89, dout);
      chk("R7 write returns old", dout, 32'h06);
      chk("R8 connected", {31'b0, connected}, 32'h1);
      dr_plain(8, 32'h00, dout);
      chk("R6 readback after write", dout, 32'h89);
      chk("R7 read keeps key", {31'b0, connected}, 32'h1);
      dr_plain(8, 32'h73, dout);
      chk("R7 bit7 clear", dout, 32'h09);
      dr_plain(8, 32'hF9, dout);
      chk("R7 key unchanged by bit7 clear", dout, 32'h09);
      dr_plain(8, 32'h00, dout);
      chk("R6 reserved bits zero", dout, 32'h89);

      // Router while unlocked
      ir_scan(6'b000010, cap);
      chk("R5 unlocked route_sel", {31'b0, route_sel}, 32'h1);
      route_tdo = 1'b1;
      dr_plain(8, 32'h00, dout);
      chk("R5 route_tdo passthrough", dout, 32'hFF);
      route_tdo = 1'b0;

      // Wrong key locks router again
      ir_scan(6'b000111, cap);
      dr_plain(8, 32'h85, dout);
      chk("R8 wrong key", {31'b0, connected}, 32'h0);
      ir_scan(6'b000010, cap);
      chk("R5 relocked route_sel", {31'b0, route_sel}, 32'h0);
      dr_plain(8, 32'h81, dout);
      chk("R5 relocked bypass", dout, 32'h02);

      // TDO moves on falling edges only
      ir_scan(6'b111111, cap);
      tick(1'b1, 1'b0, o);
      tick(1'b0, 1'b0, o);
      tick(1'b0, 1'b1, o);
      tick(1'b0, 1'b1, t1);
      @(posedge tck);
      #1;
      t2 = tdo;
      tick(1'b1, 1'b1, t3);
      chk("R9 hold across rising", {31'b0, t2}, {31'b0, t1});
      chk("R9 new bit after falling", {31'b0, t3}, 32'h1);
      tick(1'b1, 1'b0, o);
      idle_ticks(2);

      // Test-Logic-Reset via TMS clears the key
      ir_scan(6'b000111, cap);
      dr_plain(8, 32'h89, dout);
      chk("R8 reconnected", {31'b0, connected}, 32'h1);
      for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
      tick(1'b1, 1'b0, o);
      chk("R1 TLR via TMS disconnects", {31'b0, connected}, 32'h0);
      chk("R2 TLR restores IDCODE", {26'b0, instr}, 32'h04);
      idle_ticks(2);

      // Asynchronous test reset
      ir_scan(6'b000111, cap);
      dr_plain(8, 32'h89, dout);
      ir_scan(6'b111111, cap);
      @(posedge tck);
      #1;
      trst_n = 1'b0;
      #1;
      chk("R1 trst key", {31'b0, connected}, 32'h0);
      chk("R1 trst instr", {26'b0, instr}, 32'h04);
      tms = 1'b1;
      #6;
      trst_n = 1'b1;
      idle_ticks(2);
      ir_scan(6'b000111, cap);
      dr_plain(8, 32'h00, dout);
      chk("R8 key after trst", dout, 32'h06);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule